// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside a memory-mapped slave and watches two streams of accepted requests: the read-address stream and the write-address stream. Each accepted read that carries the exclusive flag opens a reservation for its transaction ID. The reservation records the address, aligned down to a reservation granule, and the transfer size. Each accepted write is judged against the open reservations. The block then reports, one cycle later, the write response code and whether the write data may reach memory.

An exclusive write succeeds only when its own ID holds a live reservation for the same granule and the same size. A successful exclusive write consumes that reservation. Any write that actually updates memory cancels every reservation it overlaps, whatever ID holds it. A failed exclusive write touches nothing. The number of reservation slots is a parameter. When every slot is taken and a new ID asks for one, the least recently installed slot gives way.

The slave logic uses the commit output to gate its memory write enable, and copies the response code into its write response channel. Data movement, storage and coordination between several slaves lie outside the block.

Top module: `excl_resv_mon`

## Requirements
- R1: Every cycle with `wr_fire` high is followed, in the next cycle only, by `bresp_vld` high. A cycle without `wr_fire` is followed by `bresp_vld` low.
- R2: A write without the exclusive flag is answered with code 2'b00 (normal OK) and `bresp_commit` high.
- R3: An exclusive write succeeds when a live reservation exists for its ID, its address lies in the reserved granule, and its size code equals the reserved one. Success means code 2'b01 (exclusive OK) and `bresp_commit` high, and the reservation is consumed.
- R4: Any other exclusive write is answered with code 2'b00 and `bresp_commit` low. Codes 2'b10 and 2'b11 (slave error, decode error) are never produced.
- R5: A committed write cancels the reservations of all IDs whose granule it overlaps. This holds for a plain write and for a successful exclusive write.
- R6: A failed exclusive write cancels no reservation.
- R7: An exclusive read from an ID that already holds a reservation moves that reservation to the new address and size. Each ID holds at most one reservation.
- R8: When all NSLOT slots hold reservations and an exclusive read arrives from an ID with none, the slot installed or refreshed longest ago is evicted.
- R9: A reservation covers the 2^GRAN_LG2-byte aligned granule of the read address. A write with size code s covers the aligned region of 2^max(GRAN_LG2,s) bytes around its address.
- R10: An exclusive write whose size code differs from the reserved size fails, even at the reserved address.
- R11: When a write and an exclusive read are accepted in the same cycle, the write is judged and applied first, and the read's reservation is installed afterwards.
- R12: An accepted read without the exclusive flag leaves all reservations unchanged.
- R13: After reset no reservation exists and `bresp_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_fire | input | 1 | A read address was accepted this cycle |
| rd_excl | input | 1 | Accepted read is exclusive |
| rd_id | input | ID_W | Transaction ID of the read |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_size | input | 3 | Size code of the read, bytes = 2^code |
| wr_fire | input | 1 | A write address was accepted this cycle |
| wr_excl | input | 1 | Accepted write is exclusive |
| wr_id | input | ID_W | Transaction ID of the write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_size | input | 3 | Size code of the write, bytes = 2^code |
| bresp_vld | output | 1 | Decision for the write accepted one cycle earlier |
| bresp_code | output | 2 | Response code: 00 OK, 01 exclusive OK |
| bresp_commit | output | 1 | Write data of that write may update memory |

## Verification
The assertions assume that `rd_fire` and `wr_fire` are single-cycle acceptance strobes with no X on their qualifiers. They also assume that the ID, address and size inputs are meaningful only while the matching strobe is high. The bench drives every request for exactly one cycle and returns every qualifier to a known zero between requests. Addresses stay in a small window, so that granule overlaps, ID collisions and slot exhaustion occur often. A bench model keyed by ID, with install stamps, supplies the expected decision for each write.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

   typedef enum logic [1:0] {
      RSP_OKAY   = 2'b00,
      RSP_EXOKAY = 2'b01,
      RSP_SLVERR = 2'b10,
      RSP_DECERR = 2'b11
   } resp_e;

   // log2 of the byte span a write of the given size code overlaps
   function automatic int unsigned cover_lg2(input int unsigned gran_lg2,
                                             input logic [2:0] size);
      int unsigned s;
      s = {29'b0, size};
      return (s > gran_lg2) ? s : gran_lg2;
   endfunction

endpackage

// File: rtl/excl_resv_slot.sv
module excl_resv_slot
   import excl_mon_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned ID_W     = 4,
   parameter int unsigned GRAN_LG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              install_i,
   input  logic              clear_i,
   input  logic [ID_W-1:0]   ins_id_i,
   input  logic [ADDR_W-1:0] ins_addr_i,
   input  logic [2:0]        ins_size_i,
   input  logic [ID_W-1:0]   rd_id_i,
   input  logic [ID_W-1:0]   wr_id_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [2:0]        wr_size_i,
   output logic              vld_o,
   output logic [ID_W-1:0]   id_o,
   output logic              rd_id_hit_o,
   output logic              wr_id_hit_o,
   output logic              wr_loc_hit_o,
   output logic              wr_size_eq_o
);

   localparam logic [ADDR_W-1:0] GRAN_MASK = {ADDR_W{1'b1}} << GRAN_LG2;

   logic              q_vld;
   logic [ID_W-1:0]   q_id;
   logic [ADDR_W-1:0] q_addr;
   logic [2:0]        q_size;
   logic [ADDR_W-1:0] wr_mask;

   // install wins over clear: the read is ordered after the write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vld  <= 1'b0;
         q_id   <= '0;
         q_addr <= '0;
         q_size <= '0;
      end else if (install_i) begin
         q_vld  <= 1'b1;
         q_id   <= ins_id_i;
         q_addr <= ins_addr_i & GRAN_MASK;
         q_size <= ins_size_i;
      end else if (clear_i) begin
         q_vld  <= 1'b0;
      end
   end

   always_comb wr_mask = {ADDR_W{1'b1}} << cover_lg2(GRAN_LG2, wr_size_i);

   assign vld_o        = q_vld;
   assign id_o         = q_id;
   assign rd_id_hit_o  = q_vld && (q_id == rd_id_i);
   assign wr_id_hit_o  = q_vld && (q_id == wr_id_i);
   assign wr_loc_hit_o = q_vld && ((q_addr & wr_mask) == (wr_addr_i & wr_mask));
   assign wr_size_eq_o = (q_size == wr_size_i);

endmodule

// File: rtl/excl_resv_age.sv
module excl_resv_age #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] touch_i,
   output logic [N-1:0] oldest_o
);

   // older_q[i][j] set: slot i was touched before slot j
   logic [N-1:0][N-1:0] older_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
               older_q[i][j] <= (i < j);
      end else if (|touch_i) begin
         for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
               if (i == j)          older_q[i][j] <= 1'b0;
               else if (touch_i[i]) older_q[i][j] <= 1'b0;
               else if (touch_i[j]) older_q[i][j] <= 1'b1;
            end
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         oldest_o[i] = 1'b1;
         for (int j = 0; j < N; j++)
            if (j != i && !older_q[i][j]) oldest_o[i] = 1'b0;
      end
   end

endmodule

// File: rtl/excl_resv_mon.sv
module excl_resv_mon
   import excl_mon_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned ID_W     = 4,
   parameter int unsigned NSLOT    = 4,
   parameter int unsigned GRAN_LG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  logic              rd_excl,
   input  logic [ID_W-1:0]   rd_id,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [2:0]        rd_size,
   input  logic              wr_fire,
   input  logic              wr_excl,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [2:0]        wr_size,
   output logic              bresp_vld,
   output logic [1:0]        bresp_code,
   output logic              bresp_commit
);

   if (NSLOT < 1) begin : g_bad_nslot
      $error("excl_resv_mon: NSLOT must be at least 1");
   end
   if (ID_W < 1) begin : g_bad_idw
      $error("excl_resv_mon: ID_W must be at least 1");
   end
   if (ADDR_W < 8 || GRAN_LG2 >= ADDR_W) begin : g_bad_addr
      $error("excl_resv_mon: ADDR_W must be >= 8 and exceed GRAN_LG2");
   end

   logic [NSLOT-1:0]           s_vld;
   logic [NSLOT-1:0][ID_W-1:0] s_id;
   logic [NSLOT-1:0]           s_rdhit;
   logic [NSLOT-1:0]           s_wrid;
   logic [NSLOT-1:0]           s_wrloc;
   logic [NSLOT-1:0]           s_szeq;
   logic [NSLOT-1:0]           s_clr;
   logic [NSLOT-1:0]           s_ins;
   logic [NSLOT-1:0]           free_after;
   logic [NSLOT-1:0]           first_free;
   logic [NSLOT-1:0]           oldest;
   logic [NSLOT-1:0]           pick;
   logic                       ex_ok;
   logic                       commit;

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      excl_resv_slot #(
         .ADDR_W   (ADDR_W),
         .ID_W     (ID_W),
         .GRAN_LG2 (GRAN_LG2)
      ) u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .install_i    (s_ins[i]),
         .clear_i      (s_clr[i]),
         .ins_id_i     (rd_id),
         .ins_addr_i   (rd_addr),
         .ins_size_i   (rd_size),
         .rd_id_i      (rd_id),
         .wr_id_i      (wr_id),
         .wr_addr_i    (wr_addr),
         .wr_size_i    (wr_size),
         .vld_o        (s_vld[i]),
         .id_o         (s_id[i]),
         .rd_id_hit_o  (s_rdhit[i]),
         .wr_id_hit_o  (s_wrid[i]),
         .wr_loc_hit_o (s_wrloc[i]),
         .wr_size_eq_o (s_szeq[i])
      );
   end

   // write side, judged against the state before this cycle
   assign ex_ok  = wr_fire && wr_excl && |(s_wrid & s_wrloc & s_szeq);
   assign commit = wr_fire && (!wr_excl || ex_ok);
   assign s_clr  = commit ? s_wrloc : '0;

   // read side, after the write has been applied
   assign free_after = ~s_vld | s_clr;

   always_comb begin
      logic found;
      found      = 1'b0;
      first_free = '0;
      for (int i = 0; i < NSLOT; i++)
         if (free_after[i] && !found) begin
            first_free[i] = 1'b1;
            found         = 1'b1;
         end
   end

   if (NSLOT == 1) begin : g_single
      assign oldest = 1'b1;
   end else begin : g_multi
      excl_resv_age #(.N(NSLOT)) u_age (
         .clk      (clk),
         .rst_n    (rst_n),
         .touch_i  (s_ins),
         .oldest_o (oldest)
      );
   end

   always_comb begin
      if (|s_rdhit)          pick = s_rdhit;
      else if (|free_after)  pick = first_free;
      else                   pick = oldest;
   end

   assign s_ins = (rd_fire && rd_excl) ? pick : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bresp_vld    <= 1'b0;
         bresp_code   <= RSP_OKAY;
         bresp_commit <= 1'b0;
      end else begin
         bresp_vld    <= wr_fire;
         bresp_code   <= ex_ok ? RSP_EXOKAY : RSP_OKAY;
         bresp_commit <= commit;
      end
   end

endmodule

// File: rtl/excl_resv_mon_chk.sv
module excl_resv_mon_chk #(
   parameter int unsigned ID_W  = 4,
   parameter int unsigned NSLOT = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       rd_fire,
   input logic                       rd_excl,
   input logic [ID_W-1:0]            rd_id,
   input logic                       wr_fire,
   input logic                       wr_excl,
   input logic [ID_W-1:0]            wr_id,
   input logic                       bresp_vld,
   input logic [1:0]                 bresp_code,
   input logic                       bresp_commit,
   input logic [NSLOT-1:0]           s_vld,
   input logic [NSLOT-1:0][ID_W-1:0] s_id
);

   logic [ID_W-1:0] last_rd_id;
   logic            rd_present;
   logic            wr_has_resv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_rd_id <= '0;
      else        last_rd_id <= rd_id;
   end

   always_comb begin
      rd_present  = 1'b0;
      wr_has_resv = 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
         if (s_vld[i] && s_id[i] == last_rd_id) rd_present  = 1'b1;
         if (s_vld[i] && s_id[i] == wr_id)      wr_has_resv = 1'b1;
      end
   end

   // R1
   resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> bresp_vld) else $error("resp_follows_chk");

   // R1
   resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_fire |=> !bresp_vld) else $error("resp_idle_chk");

   // R2
   plain_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire && !wr_excl |=> bresp_code == 2'b00 && bresp_commit)
      else $error("plain_ok_chk");

   // R4
   no_err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bresp_vld |-> !bresp_code[1]) else $error("no_err_code_chk");

   // R4
   fail_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire && wr_excl |=> bresp_commit == (bresp_code == 2'b01))
      else $error("fail_gated_chk");

   // R3
   need_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire && wr_excl && !wr_has_resv |=> bresp_code == 2'b00 && !bresp_commit)
      else $error("need_resv_chk");

   // R3
   exok_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bresp_vld && bresp_code == 2'b01 |-> $past(wr_excl))
      else $error("exok_src_chk");

   // R7
   rd_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire && rd_excl |=> rd_present) else $error("rd_install_chk");

   // R7
   for (genvar a = 0; a < NSLOT; a++) begin : g_a
      for (genvar b = a + 1; b < NSLOT; b++) begin : g_b
         uniq_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_vld[a] && s_vld[b] |-> s_id[a] != s_id[b])
            else $error("uniq_id_chk");
      end
   end

endmodule

bind excl_resv_mon excl_resv_mon_chk #(.ID_W(ID_W), .NSLOT(NSLOT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_fire      (rd_fire),
   .rd_excl      (rd_excl),
   .rd_id        (rd_id),
   .wr_fire      (wr_fire),
   .wr_excl      (wr_excl),
   .wr_id        (wr_id),
   .bresp_vld    (bresp_vld),
   .bresp_code   (bresp_code),
   .bresp_commit (bresp_commit),
   .s_vld        (s_vld),
   .s_id         (s_id)
);

// File: tb/excl_resv_mon_bench.sv
`timescale 1ns/1ps
module excl_resv_mon_bench;

   localparam int AW = 10;
   localparam int IW = 2;
   localparam int NS = 2;
   localparam int GL = 3;
   localparam int NID = 1 << IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_fire = 0, rd_excl = 0, wr_fire = 0, wr_excl = 0;
   logic [IW-1:0] rd_id = '0, wr_id = '0;
   logic [AW-1:0] rd_addr = '0, wr_addr = '0;
   logic [2:0]    rd_size = '0, wr_size = '0;
   logic          bresp_vld, bresp_commit;
   logic [1:0]    bresp_code;

   int total = 0;
   int bad   = 0;

   // bench model, one entry per ID with an install stamp
   bit m_vld   [NID];
   int m_addr  [NID];
   int m_size  [NID];
   int m_stamp [NID];
   int stamp = 0;

   always #2 clk = ~clk;

   excl_resv_mon #(.ADDR_W(AW), .ID_W(IW), .NSLOT(NS), .GRAN_LG2(GL)) u_excl_resv_mon (
      .clk(clk), .rst_n(rst_n),
      .rd_fire(rd_fire), .rd_excl(rd_excl), .rd_id(rd_id), .rd_addr(rd_addr), .rd_size(rd_size),
      .wr_fire(wr_fire), .wr_excl(wr_excl), .wr_id(wr_id), .wr_addr(wr_addr), .wr_size(wr_size),
      .bresp_vld(bresp_vld), .bresp_code(bresp_code), .bresp_commit(bresp_commit)
   );

   task automatic check(input bit ok, input string tag, input string act, input string exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%s expected=%s", tag, act, exp);
      end
   endtask

   task automatic model_step(input bit rf, re, input int rid, raddr, rsz,
                             input bit wf, we, input int wid, waddr, wsz,
                             output int code, output int cmt);
      int span, mask, cnt, victim, best;
      bit ok;
      span = (wsz > GL) ? wsz : GL;
      mask = ~((1 << span) - 1);
      ok   = wf && we && m_vld[wid] && ((m_addr[wid] & mask) == (waddr & mask))
             && (m_size[wid] == wsz);
      cmt  = (wf && (!we || ok)) ? 1 : 0;
      code = ok ? 1 : 0;
      if (cmt == 1)
         for (int k = 0; k < NID; k++)
            if (m_vld[k] && ((m_addr[k] & mask) == (waddr & mask))) m_vld[k] = 0;
      if (rf && re) begin
         if (!m_vld[rid]) begin
            cnt = 0;
            for (int k = 0; k < NID; k++) if (m_vld[k]) cnt++;
            if (cnt == NS) begin
               victim = -1; best = 0;
               for (int k = 0; k < NID; k++)
                  if (m_vld[k] && (victim < 0 || m_stamp[k] < best)) begin
                     victim = k; best = m_stamp[k];
                  end
               m_vld[victim] = 0;
            end
         end
         stamp++;
         m_vld[rid]   = 1;
         m_addr[rid]  = raddr & ~((1 << GL) - 1);
         m_size[rid]  = rsz;
         m_stamp[rid] = stamp;
      end
   endtask

   // ec/ecm < 0: take the expectation from the model
   task automatic do_op(input bit rf, re, input int rid, raddr, rsz,
                        input bit wf, we, input int wid, waddr, wsz,
                        input int ec, ecm, input string tag);
      int mc, mm, xc, xm;
      @(negedge clk);
      rd_fire = rf; rd_excl = re; rd_id = IW'(rid); rd_addr = AW'(raddr); rd_size = 3'(rsz);
      wr_fire = wf; wr_excl = we; wr_id = IW'(wid); wr_addr = AW'(waddr); wr_size = 3'(wsz);
      model_step(rf, re, rid, raddr, rsz, wf, we, wid, waddr, wsz, mc, mm);
      xc = (ec < 0) ? mc : ec;
      xm = (ecm < 0) ? mm : ecm;
      @(negedge clk);
      rd_fire = 0; rd_excl = 0; wr_fire = 0; wr_excl = 0;
      if (wf)
         check(bresp_vld && int'(bresp_code) == xc && int'(bresp_commit) == xm, tag,
               $sformatf("vld=%0b code=%0d commit=%0b", bresp_vld, bresp_code, bresp_commit),
               $sformatf("vld=1 code=%0d commit=%0d", xc, xm));
      else
         check(!bresp_vld, tag, $sformatf("vld=%0b", bresp_vld), "vld=0");
   endtask

   task automatic exrd(input int id, addr, input string tag);
      do_op(1, 1, id, addr, 2, 0, 0, 0, 0, 0, -1, -1, tag);
   endtask

   task automatic wrop(input bit ex, input int id, addr, sz, ec, ecm, input string tag);
      do_op(0, 0, 0, 0, 0, 1, ex, id, addr, sz, ec, ecm, tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      for (int k = 0; k < NID; k++) begin m_vld[k] = 0; m_addr[k] = 0; m_size[k] = 0; m_stamp[k] = 0; end
      repeat (3) @(negedge clk);
      // R13 reset state
      check(!bresp_vld, "R13", $sformatf("vld=%0b", bresp_vld), "vld=0");
      rst_n = 1'b1;
      @(negedge clk);
      check(!bresp_vld, "R13", $sformatf("vld=%0b", bresp_vld), "vld=0");
      wrop(1, 0, 'h00, 2, 0, 0, "R13");

      // R2 plain write
      wrop(0, 1, 'h40, 2, 0, 1, "R2");
      // R3 success then consumed
      exrd(0, 'h10, "R3");
      wrop(1, 0, 'h10, 2, 1, 1, "R3");
      wrop(1, 0, 'h10, 2, 0, 0, "R4");
      // R5 plain write to the granule kills both IDs
      exrd(0, 'h20, "R5");
      exrd(1, 'h20, "R5");
      wrop(0, 2, 'h24, 2, 0, 1, "R5");
      wrop(1, 0, 'h20, 2, 0, 0, "R5");
      wrop(1, 1, 'h20, 2, 0, 0, "R5");
      // R5 successful exclusive write kills the other ID
      exrd(0, 'h30, "R5");
      exrd(1, 'h30, "R5");
      wrop(1, 0, 'h30, 2, 1, 1, "R5");
      wrop(1, 1, 'h30, 2, 0, 0, "R5");
      // R6 failed exclusive write leaves others alone
      exrd(0, 'h18, "R6");
      wrop(1, 1, 'h18, 2, 0, 0, "R6");
      wrop(1, 0, 'h18, 2, 1, 1, "R6");
      // R7 re-read moves the reservation
      exrd(0, 'h08, "R7");
      exrd(0, 'h28, "R7");
      wrop(1, 0, 'h08, 2, 0, 0, "R7");
      wrop(1, 0, 'h28, 2, 1, 1, "R7");
      // R8 eviction of the oldest
      exrd(0, 'h00, "R8");
      exrd(1, 'h08, "R8");
      exrd(2, 'h10, "R8");
      wrop(1, 0, 'h00, 2, 0, 0, "R8");
      wrop(1, 1, 'h08, 2, 1, 1, "R8");
      wrop(1, 2, 'h10, 2, 1, 1, "R8");
      // R8 refresh changes the victim
      exrd(0, 'h00, "R8");
      exrd(1, 'h08, "R8");
      exrd(0, 'h00, "R8");
      exrd(2, 'h10, "R8");
      wrop(1, 1, 'h08, 2, 0, 0, "R8");
      wrop(1, 0, 'h00, 2, 1, 1, "R8");
      wrop(1, 2, 'h10, 2, 1, 1, "R8");
      // R9 granule and wide-write coverage
      exrd(0, 'h10, "R9");
      wrop(0, 1, 'h18, 2, 0, 1, "R9");
      wrop(1, 0, 'h14, 2, 1, 1, "R9");
      exrd(0, 'h08, "R9");
      wrop(0, 1, 'h00, 4, 0, 1, "R9");
      wrop(1, 0, 'h08, 2, 0, 0, "R9");
      // R10 size mismatch
      exrd(1, 'h20, "R10");
      wrop(1, 1, 'h20, 1, 0, 0, "R10");
      wrop(1, 1, 'h20, 2, 1, 1, "R10");
      // R11 same-cycle ordering
      do_op(1, 1, 0, 'h30, 2, 1, 0, 3, 'h30, 2, 0, 1, "R11");
      wrop(1, 0, 'h30, 2, 1, 1, "R11");
      exrd(1, 'h38, "R11");
      do_op(1, 1, 0, 'h38, 2, 1, 0, 3, 'h38, 2, 0, 1, "R11");
      wrop(1, 1, 'h38, 2, 0, 0, "R11");
      wrop(1, 0, 'h38, 2, 1, 1, "R11");
      // R12 plain read ignored
      exrd(0, 'h10, "R12");
      do_op(1, 0, 0, 'h20, 2, 0, 0, 0, 0, 0, -1, -1, "R12");
      wrop(1, 0, 'h10, 2, 1, 1, "R12");

      // sweep with model expectations (R3 R4 R5 R8)
      r = 32'h1234_5678;
      for (int n = 0; n < 3000; n++) begin
         r ^= r << 13; r ^= r >> 17; r ^= r << 5;
         do_op(r[0], r[1], int'(r[3:2]), int'(r[9:4]), int'(r[11:10]),
               r[12] | r[13], r[14], int'(r[16:15]), int'(r[22:17]),
               (r[25] & r[26]) ? 4 : int'(r[24:23]), -1, -1, "R4");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule